// File: doc/BRIEF.md
# Sequential Instruction Prefetch Buffer

This block sits beside a direct-mapped instruction cache and holds a single line that was fetched ahead of demand. When the instruction cache misses, the block does two things in the same cycle. It forwards the demand request to the second-level cache, and it compares the missing line address with the line it holds. If they match, the block hands the requested 64-bit word to the fetch unit, writes the whole line into the instruction cache, and cancels the demand request, all in that same cycle.

Every miss also launches a fetch of the following line, at the miss address plus one line. This fetch is skipped when that line would lie in a different page, because no translation is available for it. The prefetched line returns from the second-level cache as a series of beats. It becomes usable only once the last beat has arrived. A later miss throws away whatever the buffer held and aborts any prefetch still in flight.

Protocol assumption: once `pf_abort` is raised, the second-level cache sends no further beats for the aborted request.

Top module: `ifetch_stream_buf`

## Requirements
- R1: After reset, and after any later reset, the buffer is empty. The next miss does not hit, and `hit`, `pf_req_valid`, `pf_abort` and `dmd_req_valid` are low while no miss is presented.
- R2: In the cycle `miss_valid` is high, `dmd_req_valid` is high and `dmd_req_blk` equals `miss_paddr[PA_W-1:5]`, which is the line address (line size 32 bytes).
- R3: A miss whose line address equals the completed buffered line raises `hit`, `dmd_cancel` and `fill_valid` in the same cycle. In that cycle `fill_blk` equals the miss line address and `fill_data` carries the whole line. Otherwise all three outputs stay low.
- R4: On a hit, `crit_word` is 64-bit word k of the line, where k = `miss_paddr[4:3]`. Word k occupies bits [64k+63:64k] of `fill_data`.
- R5: Every miss whose next line lies in the same 8 KB page raises `pf_req_valid` in the miss cycle, with `pf_req_blk` equal to the miss line address plus one.
- R6: When the next line lies in a different page (its address bits above bit 12 differ from those of the miss, including wrap-around at the top of the address space), `pf_req_valid` stays low and the buffer stays empty.
- R7: Prefetch beats are 128 bits wide. Beat i fills bits [128i+127:128i] of the line, and two beats complete a line. A miss to a line whose beats have not all arrived does not hit.
- R8: A miss raises `pf_abort` in its cycle exactly when a prefetch is still incomplete. Any miss empties the buffer, so the old line can no longer hit.
- R9: `pf_rsp_valid` beats that arrive while no prefetch is outstanding are ignored and do not make the buffer valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Instruction cache miss this cycle |
| miss_paddr | input | PA_W | Physical byte address of the miss |
| hit | output | 1 | Miss found in the buffer |
| crit_word | output | WORD_W | Requested word, valid with `hit` |
| fill_valid | output | 1 | Write line into instruction cache |
| fill_blk | output | PA_W-5 | Line address of the fill |
| fill_data | output | LINE_BYTES*8 | Line data for the fill |
| dmd_req_valid | output | 1 | Demand request to second level |
| dmd_req_blk | output | PA_W-5 | Demand line address |
| dmd_cancel | output | 1 | Cancel the demand request of this cycle |
| pf_req_valid | output | 1 | Prefetch request to second level |
| pf_req_blk | output | PA_W-5 | Prefetch line address |
| pf_abort | output | 1 | Abort the outstanding prefetch |
| pf_rsp_valid | input | 1 | Prefetch beat valid |
| pf_rsp_data | input | BEAT_W | Prefetch beat data |

## Verification
The bound checker watches every cycle for the structural rules:
- a cancel or fill never appears without a demand request;
- prefetch and abort requests occur only alongside a miss;
- a prefetch never leaves the page of its miss;
- a hit needs every beat of an outstanding prefetch.

The checker cannot show data correctness, and only the bench scenarios demonstrate it: the right critical word, the exact line placed on the fill port, invalidation of an old line by an unrelated miss, and the way the buffer ignores stray beats after an abort or a page-crossing miss. The bench therefore walks a chain of sequential misses, adding partial fills, page-edge lines, a wrap-around address and a mid-run reset.

// File: rtl/spb_pkg.sv
package spb_pkg;
    localparam int unsigned DEF_PA_W       = 34;
    localparam int unsigned DEF_LINE_BYTES = 32;
    localparam int unsigned DEF_WORD_W     = 64;
    localparam int unsigned DEF_BEAT_W     = 128;
    localparam int unsigned DEF_PAGE_BYTES = 8192;
endpackage

// File: rtl/spb_next_blk.sv
module spb_next_blk #(
    parameter int unsigned BA_W = 29,
    parameter int unsigned PG_W = 8
) (
    input  logic [BA_W-1:0] blk,
    output logic [BA_W-1:0] nxt,
    output logic            same_page
);
    assign nxt       = blk + BA_W'(1);
    // Line index within a page is the low PG_W bits; the rest names the page.
    assign same_page = (nxt[BA_W-1:PG_W] == blk[BA_W-1:PG_W]);
endmodule

// File: rtl/spb_tag_cmp.sv
module spb_tag_cmp #(
    parameter int unsigned BA_W = 29
) (
    input  logic            entry_vld,
    input  logic [BA_W-1:0] entry_tag,
    input  logic [BA_W-1:0] probe,
    output logic            match
);
    assign match = entry_vld && (entry_tag == probe);
endmodule

// File: rtl/spb_word_sel.sv
module spb_word_sel #(
    parameter int unsigned WORDS  = 4,
    parameter int unsigned WORD_W = 64,
    parameter int unsigned WSEL_W = 2
) (
    input  logic [WORDS*WORD_W-1:0] line,
    input  logic [WSEL_W-1:0]       sel,
    output logic [WORD_W-1:0]       word
);
    logic [WORD_W-1:0] slot [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_slot
        assign slot[w] = line[w*WORD_W +: WORD_W];
    end

    assign word = slot[sel];
endmodule

// File: rtl/ifetch_stream_buf.sv
module ifetch_stream_buf #(
    parameter int unsigned PA_W       = spb_pkg::DEF_PA_W,
    parameter int unsigned LINE_BYTES = spb_pkg::DEF_LINE_BYTES,
    parameter int unsigned WORD_W     = spb_pkg::DEF_WORD_W,
    parameter int unsigned BEAT_W     = spb_pkg::DEF_BEAT_W,
    parameter int unsigned PAGE_BYTES = spb_pkg::DEF_PAGE_BYTES
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  miss_valid,
    input  logic [PA_W-1:0]                       miss_paddr,
    output logic                                  hit,
    output logic [WORD_W-1:0]                     crit_word,
    output logic                                  fill_valid,
    output logic [PA_W-$clog2(LINE_BYTES)-1:0]    fill_blk,
    output logic [LINE_BYTES*8-1:0]               fill_data,
    output logic                                  dmd_req_valid,
    output logic [PA_W-$clog2(LINE_BYTES)-1:0]    dmd_req_blk,
    output logic                                  dmd_cancel,
    output logic                                  pf_req_valid,
    output logic [PA_W-$clog2(LINE_BYTES)-1:0]    pf_req_blk,
    output logic                                  pf_abort,
    input  logic                                  pf_rsp_valid,
    input  logic [BEAT_W-1:0]                     pf_rsp_data
);
    localparam int unsigned OFS_W  = $clog2(LINE_BYTES);
    localparam int unsigned BA_W   = PA_W - OFS_W;
    localparam int unsigned LINE_W = LINE_BYTES * 8;
    localparam int unsigned WORDS  = LINE_W / WORD_W;
    localparam int unsigned WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int unsigned BEATS  = LINE_W / BEAT_W;
    localparam int unsigned CNT_W  = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int unsigned PG_W   = $clog2(PAGE_BYTES) - OFS_W;
    localparam int unsigned WLSB   = OFS_W - WSEL_W;

    typedef struct packed {
        logic              vld;
        logic              busy;
        logic [BA_W-1:0]   tag;
        logic [CNT_W-1:0]  beat;
        logic [LINE_W-1:0] line;
    } buf_state_t;

    buf_state_t st_q, st_d;

    logic [BA_W-1:0]   miss_blk;
    logic [BA_W-1:0]   next_blk;
    logic              next_same_page;
    logic              tag_match;
    logic [WSEL_W-1:0] word_idx;
    logic              unused_low;

    assign miss_blk   = miss_paddr[PA_W-1:OFS_W];
    assign word_idx   = miss_paddr[OFS_W-1:WLSB];
    assign unused_low = ^miss_paddr[WLSB-1:0];

    spb_next_blk #(.BA_W(BA_W), .PG_W(PG_W)) u_next (
        .blk       (miss_blk),
        .nxt       (next_blk),
        .same_page (next_same_page)
    );

    spb_tag_cmp #(.BA_W(BA_W)) u_cmp (
        .entry_vld (st_q.vld),
        .entry_tag (st_q.tag),
        .probe     (miss_blk),
        .match     (tag_match)
    );

    spb_word_sel #(.WORDS(WORDS), .WORD_W(WORD_W), .WSEL_W(WSEL_W)) u_sel (
        .line (st_q.line),
        .sel  (word_idx),
        .word (crit_word)
    );

    assign hit           = miss_valid && tag_match;
    assign fill_valid    = hit;
    assign fill_blk      = miss_blk;
    assign fill_data     = st_q.line;
    assign dmd_req_valid = miss_valid;
    assign dmd_req_blk   = miss_blk;
    assign dmd_cancel    = hit;
    assign pf_req_valid  = miss_valid && next_same_page;
    assign pf_req_blk    = next_blk;
    assign pf_abort      = miss_valid && st_q.busy;

    always_comb begin
        st_d = st_q;
        if (miss_valid) begin
            // Any miss consumes or discards the buffer and restarts the stream.
            st_d.vld  = 1'b0;
            st_d.busy = next_same_page;
            st_d.tag  = next_blk;
            st_d.beat = '0;
        end else if (st_q.busy && pf_rsp_valid) begin
            for (int b = 0; b < BEATS; b++) begin
                if (st_q.beat == CNT_W'(b)) begin
                    st_d.line[b*BEAT_W +: BEAT_W] = pf_rsp_data;
                end
            end
            if (st_q.beat == CNT_W'(BEATS - 1)) begin
                st_d.busy = 1'b0;
                st_d.vld  = 1'b1;
                st_d.beat = '0;
            end else begin
                st_d.beat = st_q.beat + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/spb_checker.sv
module spb_checker #(
    parameter int unsigned PA_W       = 34,
    parameter int unsigned LINE_BYTES = 32,
    parameter int unsigned BEAT_W     = 128,
    parameter int unsigned PAGE_BYTES = 8192
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               miss_valid,
    input logic                               hit,
    input logic                               fill_valid,
    input logic                               dmd_req_valid,
    input logic                               dmd_cancel,
    input logic                               pf_req_valid,
    input logic [PA_W-$clog2(LINE_BYTES)-1:0] pf_req_blk,
    input logic [PA_W-$clog2(LINE_BYTES)-1:0] dmd_req_blk,
    input logic                               pf_abort,
    input logic                               pf_rsp_valid
);
    localparam int unsigned OFS_W = $clog2(LINE_BYTES);
    localparam int unsigned BA_W  = PA_W - OFS_W;
    localparam int unsigned PG_W  = $clog2(PAGE_BYTES) - OFS_W;
    localparam int unsigned BEATS = LINE_BYTES * 8 / BEAT_W;
    localparam int unsigned GOT_W = $clog2(BEATS + 1);

    logic             pend_q;
    logic [GOT_W-1:0] got_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            got_q  <= '0;
        end else if (miss_valid) begin
            pend_q <= pf_req_valid;
            got_q  <= '0;
        end else if (pend_q && pf_rsp_valid && (got_q < GOT_W'(BEATS))) begin
            got_q <= got_q + GOT_W'(1);
        end
    end

    // R3
    a_r3_cancel_needs_fill: assert property (@(posedge clk) disable iff (!rst_n)
        dmd_cancel |-> (dmd_req_valid && fill_valid && hit));
    // R5
    a_r5_pf_only_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        pf_req_valid |-> dmd_req_valid);
    // R6
    a_r6_pf_same_page: assert property (@(posedge clk) disable iff (!rst_n)
        pf_req_valid |-> (pf_req_blk[BA_W-1:PG_W] == dmd_req_blk[BA_W-1:PG_W]));
    // R7
    a_r7_hit_needs_all_beats: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (pend_q && (got_q == GOT_W'(BEATS))));
    // R8
    a_r8_abort_when_incomplete: assert property (@(posedge clk) disable iff (!rst_n)
        pf_abort |-> (miss_valid && pend_q && (got_q < GOT_W'(BEATS))));
endmodule

bind ifetch_stream_buf spb_checker #(
    .PA_W(PA_W), .LINE_BYTES(LINE_BYTES), .BEAT_W(BEAT_W), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid    (miss_valid),
    .hit           (hit),
    .fill_valid    (fill_valid),
    .dmd_req_valid (dmd_req_valid),
    .dmd_cancel    (dmd_cancel),
    .pf_req_valid  (pf_req_valid),
    .pf_req_blk    (pf_req_blk),
    .dmd_req_blk   (dmd_req_blk),
    .pf_abort      (pf_abort),
    .pf_rsp_valid  (pf_rsp_valid)
);

// File: tb/tb_ifetch_stream_buf.sv
module tb_ifetch_stream_buf;
    localparam int PA_W = 34;
    localparam int BA_W = 29;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              miss_valid = 1'b0;
    logic [PA_W-1:0]   miss_paddr = '0;
    logic              hit, fill_valid, dmd_req_valid, dmd_cancel, pf_req_valid, pf_abort;
    logic [63:0]       crit_word;
    logic [BA_W-1:0]   fill_blk, dmd_req_blk, pf_req_blk;
    logic [255:0]      fill_data;
    logic              pf_rsp_valid = 1'b0;
    logic [127:0]      pf_rsp_data = '0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ifetch_stream_buf dut (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_paddr(miss_paddr),
        .hit(hit), .crit_word(crit_word), .fill_valid(fill_valid), .fill_blk(fill_blk),
        .fill_data(fill_data), .dmd_req_valid(dmd_req_valid), .dmd_req_blk(dmd_req_blk),
        .dmd_cancel(dmd_cancel), .pf_req_valid(pf_req_valid), .pf_req_blk(pf_req_blk),
        .pf_abort(pf_abort), .pf_rsp_valid(pf_rsp_valid), .pf_rsp_data(pf_rsp_data)
    );

    typedef struct packed {
        logic [PA_W-1:0] pa;
        logic            exp_hit;
        logic            exp_pf;
        logic [1:0]      beats;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{34'h0_0000_1000, 1'b0, 1'b1, 2'd2},
        '{34'h0_0000_1028, 1'b1, 1'b1, 2'd2},
        '{34'h0_0000_1058, 1'b1, 1'b1, 2'd1},
        '{34'h0_0000_1070, 1'b0, 1'b1, 2'd2},
        '{34'h0_0000_1FE0, 1'b0, 1'b0, 2'd0},
        '{34'h0_0000_1080, 1'b0, 1'b1, 2'd2},
        '{34'h0_0000_10A0, 1'b1, 1'b1, 2'd2},
        '{34'h3_FFFF_FFE0, 1'b0, 1'b0, 2'd0},
        '{34'h2_0000_1FC0, 1'b0, 1'b1, 2'd2},
        '{34'h2_0000_1FF8, 1'b1, 1'b0, 2'd0}
    };

    function automatic logic [63:0] word_of(input logic [BA_W-1:0] blk, input int k);
        return {3'b000, blk, 24'hC0FFEE, 8'(k)};
    endfunction

    function automatic logic [255:0] line_of(input logic [BA_W-1:0] blk);
        return {word_of(blk, 3), word_of(blk, 2), word_of(blk, 1), word_of(blk, 0)};
    endfunction

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    logic [BA_W-1:0] pf_blk = '0;
    logic            pf_busy = 1'b0;
    int              pf_got = 0;

    // Present one miss at a negedge, check combinational results, clear after the edge.
    task automatic do_miss(input logic [PA_W-1:0] pa, input logic e_hit,
                           input logic e_pf, input logic e_abort);
        logic [BA_W-1:0] blk;
        blk = pa[PA_W-1:5];
        miss_valid = 1'b1;
        miss_paddr = pa;
        #1;
        check("R2 dmd_req_valid", 256'(dmd_req_valid), 256'(1'b1));
        check("R2 dmd_req_blk", 256'(dmd_req_blk), 256'(blk));
        check("R3 hit", 256'(hit), 256'(e_hit));
        check("R3 dmd_cancel", 256'(dmd_cancel), 256'(e_hit));
        check("R3 fill_valid", 256'(fill_valid), 256'(e_hit));
        if (e_hit) begin
            check("R3 fill_blk", 256'(fill_blk), 256'(blk));
            check("R3 fill_data", fill_data, line_of(blk));
            check("R4 crit_word", 256'(crit_word), 256'(word_of(blk, int'(pa[4:3]))));
        end
        check("R5 R6 pf_req_valid", 256'(pf_req_valid), 256'(e_pf));
        if (e_pf) check("R5 pf_req_blk", 256'(pf_req_blk), 256'(blk + 1'b1));
        check("R8 pf_abort", 256'(pf_abort), 256'(e_abort));
        @(posedge clk);
        @(negedge clk);
        miss_valid = 1'b0;
        pf_blk  = blk + 1'b1;
        pf_busy = e_pf;
        pf_got  = 0;
    endtask

    // Deliver one 128-bit beat of the line pf_blk (beat i = words 2i and 2i+1).
    task automatic do_beat(input int i);
        pf_rsp_valid = 1'b1;
        pf_rsp_data  = {word_of(pf_blk, 2*i+1), word_of(pf_blk, 2*i)};
        @(posedge clk);
        @(negedge clk);
        pf_rsp_valid = 1'b0;
        pf_got = pf_got + 1;
        if (pf_got == 2) pf_busy = 1'b0;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: idle outputs after reset
        check("R1 hit idle", 256'(hit), 256'(1'b0));
        check("R1 pf_req idle", 256'(pf_req_valid), 256'(1'b0));
        check("R1 abort idle", 256'(pf_abort), 256'(1'b0));
        check("R1 dmd idle", 256'(dmd_req_valid), 256'(1'b0));
        @(negedge clk);

        // Table walk: R2..R8
        for (int v = 0; v < NV; v++) begin
            do_miss(VECS[v].pa, VECS[v].exp_hit, VECS[v].exp_pf, pf_busy);
            for (int b = 0; b < int'(VECS[v].beats); b++) do_beat(b);
            @(negedge clk);
        end

        // R9: stray beats with nothing outstanding are ignored
        pf_blk = 29'h1000_0100;
        do_beat(0);
        do_beat(1);
        do_miss(34'h2_0000_2000, 1'b0, 1'b1, 1'b0);

        // R1: reset in the middle empties a completed buffer
        do_beat(0);
        do_beat(1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        pf_busy = 1'b0;
        do_miss(34'h2_0000_2020, 1'b0, 1'b1, 1'b0);

        // R7: a single beat leaves the line unusable; R8 abort of it
        do_beat(0);
        do_miss(34'h2_0000_2040, 1'b0, 1'b1, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule